// File: doc/BRIEF.md
# Edge-Polarity GPIO Interrupt Combiner

This block merges the pin-change interrupts of two 8-bit general-purpose input ports into one interrupt request line. Every pin has two configuration bits: an enable and a polarity. Firmware sets them by writing bytes over a small write-only register bus. The polarity bit chooses which edge counts as a trigger, falling or rising. Each pin input first passes through a two-flop synchroniser. After that, an enabled pin triggers when its level goes from inactive to active. A master enable input gates whether any trigger can raise the request.

All sixteen pins share one request, and no pin has priority over another. Firmware finds the source by reading the synchronised pin levels, which the block drives on two output buses. When a pin triggers, that pin holds a lock. While the lock is held, edges on every other pin are ignored. The lock ends when the locked pin returns to its inactive level or when firmware clears that pin's enable. The request stays high until an acknowledge strobe clears it or the master enable is dropped. The acknowledge does not change any enable or polarity bit.

Top module: `gpio_irq_combiner`

## Requirements
- R1: After reset, all enable and polarity bits are 0 and `gpio_irq` is low. With no enable bit written, no edge on any pin raises the request.
- R2: A write selects its register with `cfg_addr`: 0 is the port 0 enables, 1 is the port 1 enables, 2 is the port 0 polarities and 3 is the port 1 polarities. Bit i of `cfg_wdata` belongs to pin i of that port. The write takes effect on the clock edge that samples `cfg_we` high.
- R3: A pin's active level is its synchronised input XNOR its polarity bit. Polarity 0 makes a falling edge trigger and polarity 1 makes a rising edge trigger. An edge in the other direction never triggers.
- R4: When `gpio_master_en` is low, no trigger can raise `gpio_irq`. Dropping `gpio_master_en` clears a pending request on the next clock edge, and raising it again does not restore that request.
- R5: A pin whose enable bit is 0 never raises the request.
- R6: After a pin triggers, edges on all other pins are ignored until the locked pin goes back to its inactive level or its enable bit is cleared. After that, a new edge on another pin triggers normally.
- R7: A high `irq_ack` clears `gpio_irq` on the next clock edge. The enable and polarity bits are unchanged, so the same pin triggers again on its next active edge.
- R8: `p0_level` and `p1_level` show the pin inputs delayed by two clock edges.
- R9: For an accepted edge, `gpio_irq` goes high on the third rising clock edge after the pin input changes. It is still low after the second edge.
- R10: Pins of port 0 and port 1 drive the same `gpio_irq` output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select (0/1 enables, 2/3 polarities) |
| cfg_wdata | input | 8 | Configuration write data, bit i for pin i |
| gpio_master_en | input | 1 | Master gate for the shared request |
| irq_ack | input | 1 | Acknowledge strobe, clears the pending request |
| p0_pins | input | 8 | Port 0 pin inputs (asynchronous) |
| p1_pins | input | 8 | Port 1 pin inputs (asynchronous) |
| p0_level | output | 8 | Synchronised port 0 levels for polling |
| p1_level | output | 8 | Synchronised port 1 levels for polling |
| gpio_irq | output | 1 | Shared GPIO interrupt request |

## Verification
The assertions check five things on every cycle. The request falls after the master enable goes low. A held lock keeps its pin. A new request is taken only while no lock is held and the master enable is high. An acknowledge during a lock clears the request. An enable write stores the written byte. The bench scenarios cover what needs a sequence of pin activity. That includes the edge direction chosen by polarity, the three-edge latency, and the lockout of a second pin together with both ways the lock is released. It also covers the shared request across both ports and the request triggering again after an acknowledge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PORT_W = 8;
    localparam int NPORTS = 2;
    localparam int NPINS  = PORT_W * NPORTS;

    typedef enum logic [1:0] {
        SEL_EN_P0  = 2'd0,
        SEL_EN_P1  = 2'd1,
        SEL_POL_P0 = 2'd2,
        SEL_POL_P1 = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] pol;
    } pin_cfg_t;

    function automatic logic [NPINS-1:0] active_level(
        input logic [NPINS-1:0] lvl,
        input logic [NPINS-1:0] pol
    );
        return ~(lvl ^ pol);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int PW = PORT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [1:0]      addr,
    input  logic [PW-1:0]   wdata,
    output logic [2*PW-1:0] en,
    output logic [2*PW-1:0] pol
);
    cfg_sel_e sel;
    assign sel = cfg_sel_e'(addr);

    logic [PW-1:0] en_q  [2];
    logic [PW-1:0] pol_q [2];

    for (genvar p = 0; p < 2; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[p]  <= '0;
                pol_q[p] <= '0;
            end else if (we) begin
                if (sel == (p == 0 ? SEL_EN_P0 : SEL_EN_P1))
                    en_q[p] <= wdata;
                if (sel == (p == 0 ? SEL_POL_P0 : SEL_POL_P1))
                    pol_q[p] <= wdata;
            end
        end
        assign en[p*PW +: PW]  = en_q[p];
        assign pol[p*PW +: PW] = pol_q[p];
    end

    // R2
    wr_en_p0_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 2'd0) |=> (en[PW-1:0] == $past(wdata)));
endmodule

// File: rtl/gpio_edge_trig.sv
module gpio_edge_trig
    import gpio_irq_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] en,
    output logic [N-1:0] act,
    output logic [N-1:0] trig
);
    logic [N-1:0] act_prev_q;

    assign act = active_level(lvl, pol);

    for (genvar i = 0; i < N; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) act_prev_q[i] <= 1'b1;
            else     act_prev_q[i] <= act[i];
        end
        assign trig[i] = en[i] & act[i] & ~act_prev_q[i];
    end
endmodule

// File: rtl/gpio_lock_arb.sv
module gpio_lock_arb
    import gpio_irq_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] act,
    input  logic [N-1:0] en,
    input  logic         master_en,
    input  logic         ack,
    output logic         irq
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic          locked_q;
    logic [IW-1:0] idx_q;
    logic          pend_q;
    logic [IW-1:0] pick;
    logic          accept;
    logic          unlock;

    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (trig[i]) pick = IW'(i);
        end
    end

    assign accept = !locked_q && master_en && (|trig);
    assign unlock = locked_q && (!act[idx_q] || !en[idx_q]);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            idx_q    <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (accept) begin
                locked_q <= 1'b1;
                idx_q    <= pick;
            end else if (unlock) begin
                locked_q <= 1'b0;
            end
            if (!master_en)  pend_q <= 1'b0;
            else if (accept) pend_q <= 1'b1;
            else if (ack)    pend_q <= 1'b0;
        end
    end

    assign irq = pend_q;

    // R4
    master_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !master_en |=> !irq);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_q && en[idx_q] && act[idx_q]) |=> (locked_q && idx_q == $past(idx_q)));

    // R6
    new_req_free_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(!locked_q && master_en));

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && locked_q) |=> !pend_q);
endmodule

// File: rtl/gpio_irq_combiner.sv
module gpio_irq_combiner
    import gpio_irq_pkg::*;
#(
    parameter int PW = PORT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [PW-1:0] cfg_wdata,
    input  logic          gpio_master_en,
    input  logic          irq_ack,
    input  logic [PW-1:0] p0_pins,
    input  logic [PW-1:0] p1_pins,
    output logic [PW-1:0] p0_level,
    output logic [PW-1:0] p1_level,
    output logic          gpio_irq
);
    localparam int N = 2 * PW;

    logic [N-1:0] lvl;
    logic [N-1:0] en;
    logic [N-1:0] pol;
    logic [N-1:0] act;
    logic [N-1:0] trig;

    gpio_in_sync #(.W(N)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({p1_pins, p0_pins}),
        .q   (lvl)
    );

    gpio_cfg_regs #(.PW(PW)) cfg_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .en    (en),
        .pol   (pol)
    );

    gpio_edge_trig #(.N(N)) trig_i (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .pol  (pol),
        .en   (en),
        .act  (act),
        .trig (trig)
    );

    gpio_lock_arb #(.N(N)) arb_i (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .act       (act),
        .en        (en),
        .master_en (gpio_master_en),
        .ack       (irq_ack),
        .irq       (gpio_irq)
    );

    assign p0_level = lvl[PW-1:0];
    assign p1_level = lvl[N-1:PW];
endmodule

// File: tb/gpio_irq_combiner_tb.sv
module gpio_irq_combiner_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       master = 1'b0;
    logic       ack = 1'b0;
    logic [7:0] p0 = 8'h00;
    logic [7:0] p1 = 8'h00;
    logic [7:0] l0;
    logic [7:0] l1;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_combiner dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_we         (cfg_we),
        .cfg_addr       (cfg_addr),
        .cfg_wdata      (cfg_wdata),
        .gpio_master_en (master),
        .irq_ack        (ack),
        .p0_pins        (p0),
        .p1_pins        (p1),
        .p0_level       (l0),
        .p1_level       (l1),
        .gpio_irq       (irq)
    );

    task automatic check(input string req, input logic [15:0] act_v, input logic [15:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 irq after reset", {15'd0, irq}, 16'd0);
        master = 1'b1;
        p0 = 8'hFF; p1 = 8'hFF;
        tick(4);
        p0 = 8'h00; p1 = 8'h00;
        tick(5);
        check("R1 no irq with reset enables", {15'd0, irq}, 16'd0);
        p0 = 8'hFF; p1 = 8'hFF;
        tick(4);
    endtask

    task automatic t_raw();
        p0 = 8'hA5; p1 = 8'h3C;
        tick(1);
        check("R8 level after one edge", {l1, l0}, 16'hFFFF);
        tick(1);
        check("R8 level after two edges", {l1, l0}, 16'h3CA5);
        p0 = 8'hFF; p1 = 8'hFF;
        tick(4);
    endtask

    task automatic t_disabled();
        wr(2'd0, 8'hFE);
        p0[0] = 1'b0;
        tick(5);
        check("R5 disabled pin0 no irq", {15'd0, irq}, 16'd0);
        p0[0] = 1'b1;
        tick(4);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_falling();
        wr(2'd0, 8'h01);
        p0[0] = 1'b0;
        tick(2);
        check("R9 irq low after two edges", {15'd0, irq}, 16'd0);
        tick(1);
        check("R3 R9 falling edge irq on third edge", {15'd0, irq}, 16'd1);
        do_ack();
        check("R7 ack clears irq", {15'd0, irq}, 16'd0);
        p0[0] = 1'b1;
        tick(4);
        p0[0] = 1'b0;
        tick(4);
        check("R7 enable kept after ack, retrigger", {15'd0, irq}, 16'd1);
        do_ack();
        p0[0] = 1'b1;
        tick(4);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_rising();
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h02);
        tick(3);
        check("R3 no irq on enabling an active pin", {15'd0, irq}, 16'd0);
        p0[1] = 1'b0;
        tick(5);
        check("R3 falling edge ignored with polarity 1", {15'd0, irq}, 16'd0);
        p0[1] = 1'b1;
        tick(3);
        check("R3 rising edge irq with polarity 1", {15'd0, irq}, 16'd1);
        do_ack();
        p0[1] = 1'b0;
        tick(4);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        p0[1] = 1'b1;
        tick(4);
    endtask

    task automatic t_lockout();
        wr(2'd0, 8'h03);
        p0[0] = 1'b0;
        tick(4);
        check("R6 pin0 first trigger", {15'd0, irq}, 16'd1);
        do_ack();
        p0[1] = 1'b0;
        tick(5);
        check("R6 pin1 blocked while pin0 locked", {15'd0, irq}, 16'd0);
        p0[1] = 1'b1;
        tick(3);
        p0[0] = 1'b1;
        tick(4);
        p0[1] = 1'b0;
        tick(4);
        check("R6 pin1 triggers after pin0 inactive", {15'd0, irq}, 16'd1);
        do_ack();
        p0[1] = 1'b1;
        tick(4);
        p0[0] = 1'b0;
        tick(4);
        do_ack();
        wr(2'd0, 8'h02);
        tick(2);
        p0[1] = 1'b0;
        tick(4);
        check("R6 pin1 triggers after pin0 disabled", {15'd0, irq}, 16'd1);
        do_ack();
        p0 = 8'hFF;
        tick(4);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_port1();
        wr(2'd1, 8'h80);
        p1[7] = 1'b0;
        tick(4);
        check("R10 port1 pin7 drives shared irq", {15'd0, irq}, 16'd1);
        do_ack();
        p1[7] = 1'b1;
        tick(4);
    endtask

    task automatic t_master();
        master = 1'b0;
        p1[7] = 1'b0;
        tick(5);
        check("R4 no irq with master off", {15'd0, irq}, 16'd0);
        p1[7] = 1'b1;
        tick(4);
        master = 1'b1;
        p1[7] = 1'b0;
        tick(4);
        check("R4 irq with master on", {15'd0, irq}, 16'd1);
        master = 1'b0;
        tick(1);
        check("R4 master off drops pending", {15'd0, irq}, 16'd0);
        master = 1'b1;
        tick(2);
        check("R4 pending not restored", {15'd0, irq}, 16'd0);
        p1[7] = 1'b1;
        tick(4);
        wr(2'd1, 8'h00);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_raw();
        t_disabled();
        t_falling();
        t_rising();
        t_lockout();
        t_port1();
        t_master();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule